// File: doc/BRIEF.md
# Fan Tachometer Period Capture Channel

This block measures the period of a fan tachometer signal. A 16-bit down-counter starts each measurement at its all-ones value and steps down by one on every cycle where the prescaled tick input is high. When the selected edge of the tach signal arrives, the current count is latched into the capture register. The captured value is the all-ones value minus the number of ticks since the measurement started. The fan gives two tach pulses per revolution, so one measurement covers half a revolution.

A 4-bit compare setting can end a measurement early. It does this by comparing the count against one of two target inputs. The three stop conditions are ranked: "high" first, then "equal", then "below". A stop produces its own compare-hit strobe and leaves the capture register alone. If no edge and no compare stop arrive before the counter would pass below zero, the measurement ends with an underflow strobe.

After any event, the channel waits for the next tick. That tick reloads the counter to all-ones and starts a new measurement.

Top module: `tach_capture_chan`

## Requirements
- R1: After reset the live count is 0xFFFF, the capture register is 0, and all three strobes are low.
- R2: The first tick after reset or after any event reloads the count to 0xFFFF without decrementing. Each later tick during a measurement lowers the count by exactly one.
- R3: A tach edge is detected on the rising edge when `edge_sel` is 0 and on the falling edge when `edge_sel` is 1. The opposite edge is ignored. On a detected edge the count is latched into `capture` and `cap_strobe` pulses for one cycle.
- R4: A tick that arrives while the count is 0 ends the measurement with a one-cycle `unf_strobe`. `capture` keeps its old value.
- R5: When `cmp_cfg[3]` (the high stop) is set, the measurement ends with a compare hit in the first cycle after the reload, with the count at 0xFFFF.
- R6: When `cmp_cfg[2]` (the equal stop) is set, a compare hit fires once the count reaches the selected target. The count then holds the target value.
- R7: When `cmp_cfg[1]` (the below stop) is set, a compare hit fires at target minus one. This stop never fires when the target is 0. When the equal stop is also set, the equal stop wins.
- R8: A compare hit pulses `hit_strobe` for one cycle instead of `cap_strobe`, and `capture` keeps its previous value.
- R9: `cmp_cfg[0]` = 0 compares against `target_a`, and `cmp_cfg[0]` = 1 compares against `target_b`.
- R10: Between an event and the next reload tick, tach edges produce no event and the count does not change.
- R11: While `enable` is low, the count holds, no strobe is raised, and ticks and edges are ignored.
- R12: At most one of the three strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Channel enable |
| tick | input | 1 | Prescaled count enable, one cycle per tick |
| tach_in | input | 1 | Asynchronous tachometer signal |
| edge_sel | input | 1 | 0 = rising edge captures, 1 = falling edge captures |
| target_a | input | 16 | Compare target used when cmp_cfg[0] = 0 |
| target_b | input | 16 | Compare target used when cmp_cfg[0] = 1 |
| cmp_cfg | input | 4 | [3] high stop, [2] equal stop, [1] below stop, [0] target select |
| count | output | 16 | Live down-counter value |
| capture | output | 16 | Count latched at the last captured edge |
| cap_strobe | output | 1 | One-cycle pulse on a capture |
| hit_strobe | output | 1 | One-cycle pulse on a compare stop |
| unf_strobe | output | 1 | One-cycle pulse on an underflow |

## Verification
A change on `tach_in` passes through two synchronizer flops and then the event register. The capture strobe and the new `capture` value therefore appear three clock edges after the tach level changes. A tick changes `count` one edge later. A compare or underflow strobe appears one edge after the count value that causes it.

The bench drives inputs and samples outputs on falling clock edges, so sampling never races the design's registers. Expected events go into a queue before the stimulus that causes them. A monitor process pops an entry whenever any strobe is seen and compares the strobe kind together with `capture` or `count`. Any strobe that arrives with no entry in the queue is reported. Entries still queued at the end of the run are reported as missed.

// File: rtl/tach_pkg.sv
package tach_pkg;

    typedef enum logic [1:0] {
        EV_NONE      = 2'd0,
        EV_CAPTURE   = 2'd1,
        EV_HIT       = 2'd2,
        EV_UNDERFLOW = 2'd3
    } tach_evt_e;

    typedef enum logic {
        PH_RELOAD = 1'b0,
        PH_RUN    = 1'b1
    } tach_phase_e;

    // Bit order of the packed struct follows the configuration bits 3..0.
    typedef struct packed {
        logic stop_high;
        logic stop_equal;
        logic stop_below;
        logic use_alt;
    } cmp_cfg_t;

    // Ranking of events inside a running measurement: a compare stop wins
    // over a tach edge, which wins over a wrap of the counter.
    function automatic tach_evt_e pick_event(input logic hit,
                                             input logic edge_seen,
                                             input logic wrap);
        if (hit)
            return EV_HIT;
        else if (edge_seen)
            return EV_CAPTURE;
        else if (wrap)
            return EV_UNDERFLOW;
        else
            return EV_NONE;
    endfunction

endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tach_in,
    input  logic edge_sel,
    output logic edge_o
);
    logic [STAGES:0] pipe;
    logic            rise;
    logic            fall;

    always_ff @(posedge clk) begin
        if (rst)
            pipe <= '0;
        else
            pipe <= {pipe[STAGES-1:0], tach_in};
    end

    assign rise   =  pipe[STAGES-1] & ~pipe[STAGES];
    assign fall   = ~pipe[STAGES-1] &  pipe[STAGES];
    assign edge_o = edge_sel ? fall : rise;

    // A synchronized edge is a single-cycle event.
    assert_edge_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/tach_cmp.sv
module tach_cmp
    import tach_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] count,
    input  logic [W-1:0] target_a,
    input  logic [W-1:0] target_b,
    input  cmp_cfg_t     cfg,
    output logic         hit
);
    logic [W-1:0] tgt;
    logic         hi_c;
    logic         eq_c;
    logic         lo_c;

    assign tgt  = cfg.use_alt ? target_b : target_a;
    assign hi_c = cfg.stop_high;
    assign eq_c = cfg.stop_equal && (count <= tgt);
    assign lo_c = cfg.stop_below && (tgt != '0) && (count < tgt);
    // Count only moves down by one, so the first condition met is the one
    // of highest rank.
    assign hit  = hi_c | eq_c | lo_c;

endmodule

// File: rtl/tach_counter.sv
module tach_counter
    import tach_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         tick,
    input  logic         edge_seen,
    input  logic         hit,
    output logic [W-1:0] count,
    output logic [W-1:0] capture,
    output tach_evt_e    evt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    tach_phase_e phase;
    tach_evt_e   nxt_evt;

    assign nxt_evt = pick_event(hit, edge_seen, tick && (count == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_RELOAD;
            count   <= '1;
            capture <= '0;
            evt     <= EV_NONE;
        end else begin
            evt <= EV_NONE;
            if (en) begin
                if (phase == PH_RELOAD) begin
                    if (tick) begin
                        count <= '1;
                        phase <= PH_RUN;
                    end
                end else begin
                    case (nxt_evt)
                        EV_HIT: begin
                            evt   <= EV_HIT;
                            phase <= PH_RELOAD;
                        end
                        EV_CAPTURE: begin
                            capture <= count;
                            evt     <= EV_CAPTURE;
                            phase   <= PH_RELOAD;
                        end
                        EV_UNDERFLOW: begin
                            evt   <= EV_UNDERFLOW;
                            phase <= PH_RELOAD;
                        end
                        default: begin
                            if (tick)
                                count <= count - ONE;
                        end
                    endcase
                end
            end
        end
    end

    assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
        (en && phase == PH_RELOAD && tick) |=> (count == '1 && phase == PH_RUN));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (en && phase == PH_RUN && !hit && !edge_seen && tick && count != '0)
        |=> (count == $past(count) - ONE));

    assert_keep_capture_R8: assert property (@(posedge clk) disable iff (rst)
        (evt == EV_HIT || evt == EV_UNDERFLOW) |-> (capture == $past(capture)));

    assert_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        !en |=> (count == $past(count) && evt == EV_NONE));

    assert_wait_R10: assert property (@(posedge clk) disable iff (rst)
        (en && phase == PH_RELOAD && !tick) |=> (count == $past(count) && evt == EV_NONE));

endmodule

// File: rtl/tach_capture_chan.sv
module tach_capture_chan
    import tach_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick,
    input  logic             tach_in,
    input  logic             edge_sel,
    input  logic [CNT_W-1:0] target_a,
    input  logic [CNT_W-1:0] target_b,
    input  logic [3:0]       cmp_cfg,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] capture,
    output logic             cap_strobe,
    output logic             hit_strobe,
    output logic             unf_strobe
);
    cmp_cfg_t  cfg_s;
    logic      edge_seen;
    logic      hit;
    tach_evt_e evt;

    assign cfg_s = cmp_cfg_t'(cmp_cfg);

    tach_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .tach_in  (tach_in),
        .edge_sel (edge_sel),
        .edge_o   (edge_seen)
    );

    tach_cmp #(.W(CNT_W)) u_cmp (
        .count    (count),
        .target_a (target_a),
        .target_b (target_b),
        .cfg      (cfg_s),
        .hit      (hit)
    );

    tach_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .en        (enable),
        .tick      (tick),
        .edge_seen (edge_seen),
        .hit       (hit),
        .count     (count),
        .capture   (capture),
        .evt       (evt)
    );

    assign cap_strobe = (evt == EV_CAPTURE);
    assign hit_strobe = (evt == EV_HIT);
    assign unf_strobe = (evt == EV_UNDERFLOW);

endmodule

// File: tb/tb_tach_capture_chan.sv
module tb_tach_capture_chan;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b1;
    logic        tick = 1'b0;
    logic        tach_in = 1'b0;
    logic        edge_sel = 1'b0;
    logic [15:0] target_a = '0;
    logic [15:0] target_b = '0;
    logic [3:0]  cmp_cfg = '0;
    logic [15:0] count;
    logic [15:0] capture;
    logic        cap_strobe;
    logic        hit_strobe;
    logic        unf_strobe;

    int checks = 0;
    int errors = 0;

    localparam int K_CAP = 1;
    localparam int K_HIT = 2;
    localparam int K_UNF = 3;

    typedef struct {
        int          kind;
        logic [15:0] val;
        string       req;
    } exp_t;

    exp_t expq[$];

    always #5 clk = ~clk;

    tach_capture_chan dut (
        .clk(clk), .rst(rst), .enable(enable), .tick(tick), .tach_in(tach_in),
        .edge_sel(edge_sel), .target_a(target_a), .target_b(target_b),
        .cmp_cfg(cmp_cfg), .count(count), .capture(capture),
        .cap_strobe(cap_strobe), .hit_strobe(hit_strobe), .unf_strobe(unf_strobe)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_evt(input int kind, input logic [15:0] val, input string req);
        exp_t e;
        e.kind = kind;
        e.val  = val;
        e.req  = req;
        expq.push_back(e);
    endtask

    // One tick: high for exactly one rising clock edge.
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic ticks_back_to_back(input int n);
        @(negedge clk) tick = 1'b1;
        repeat (n - 1) @(negedge clk);
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic tach_to(input logic lvl);
        @(negedge clk) tach_in = lvl;
        repeat (6) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops the queue whenever any strobe shows up.
    always @(negedge clk) begin
        if (!rst) begin
            if ((cap_strobe + hit_strobe + unf_strobe) > 1) begin
                checks++;
                errors++;
                $display("FAIL R12 actual=%b%b%b expected=one strobe at most",
                         cap_strobe, hit_strobe, unf_strobe);
            end else if (cap_strobe || hit_strobe || unf_strobe) begin
                int          k;
                logic [15:0] v;
                k = cap_strobe ? K_CAP : (hit_strobe ? K_HIT : K_UNF);
                v = hit_strobe ? count : capture;
                checks++;
                if (expq.size() == 0) begin
                    errors++;
                    $display("FAIL R12 unexpected event actual=kind%0d/%h expected=none", k, v);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    if (e.kind != k || e.val !== v) begin
                        errors++;
                        $display("FAIL %s actual=kind%0d/%h expected=kind%0d/%h",
                                 e.req, k, v, e.kind, e.val);
                    end
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        check("R1 count", count, 16'hFFFF);
        check("R1 capture", capture, 16'h0000);
        check("R1 strobes", {13'd0, cap_strobe, hit_strobe, unf_strobe}, 16'h0000);

        // R2 reload then decrement; R3 rising capture
        ticks(1);
        check("R2 reload", count, 16'hFFFF);
        ticks(10);
        check("R2 decrement", count, 16'hFFF5);
        expect_evt(K_CAP, 16'hFFF5, "R3 rising");
        tach_to(1'b1);

        // R3 falling edge ignored with rising selected, then falling selected
        ticks(1);
        ticks(3);
        tach_to(1'b0);
        check("R3 wrong edge ignored", count, 16'hFFFC);
        edge_sel = 1'b1;
        tach_to(1'b1);
        check("R3 rise ignored when falling selected", count, 16'hFFFC);
        ticks(2);
        expect_evt(K_CAP, 16'hFFFA, "R3 falling");
        tach_to(1'b0);

        // R10 edges between event and reload do nothing
        tach_to(1'b1);
        tach_to(1'b0);
        check("R10 count held", count, 16'hFFFA);
        ticks(1);
        check("R2 reload after capture", count, 16'hFFFF);

        // R6 equal stop, R8 capture untouched
        edge_sel = 1'b0;
        cmp_cfg  = 4'b0100;
        target_a = 16'hFFF0;
        expect_evt(K_HIT, 16'hFFF0, "R6 equal");
        ticks(15);
        idle(3);
        check("R6 count holds target", count, 16'hFFF0);
        check("R8 capture kept", capture, 16'hFFFA);

        // R7 below stop
        cmp_cfg = 4'b0010;
        ticks(1);
        expect_evt(K_HIT, 16'hFFEF, "R7 below");
        ticks(16);
        idle(3);

        // R7 equal outranks below
        cmp_cfg  = 4'b0110;
        target_a = 16'hFFE0;
        ticks(1);
        expect_evt(K_HIT, 16'hFFE0, "R7 equal first");
        ticks(31);
        idle(3);

        // R7 below suppressed for zero target
        cmp_cfg  = 4'b0010;
        target_a = 16'h0000;
        ticks(5);
        expect_evt(K_CAP, 16'hFFFB, "R7 zero target");
        tach_to(1'b1);

        // R5 high stop right after reload
        cmp_cfg = 4'b1000;
        expect_evt(K_HIT, 16'hFFFF, "R5 high");
        ticks(1);
        idle(3);

        // R9 target_b selected
        cmp_cfg  = 4'b0101;
        target_a = 16'h0000;
        target_b = 16'hFFF8;
        expect_evt(K_HIT, 16'hFFF8, "R9 use target_b");
        ticks(8);
        idle(3);

        // R9 target_a selected, target_b ignored
        cmp_cfg  = 4'b0100;
        target_a = 16'h0100;
        ticks(11);
        check("R9 target_b ignored", count, 16'hFFF5);
        tach_to(1'b0);
        expect_evt(K_CAP, 16'hFFF5, "R9 use target_a");
        tach_to(1'b1);

        // R11 disabled channel
        cmp_cfg = 4'b0000;
        ticks(4);
        enable = 1'b0;
        ticks(5);
        tach_to(1'b0);
        tach_to(1'b1);
        check("R11 count frozen", count, 16'hFFFC);
        enable = 1'b1;
        ticks(1);
        check("R11 resumes", count, 16'hFFFB);
        tach_to(1'b0);
        expect_evt(K_CAP, 16'hFFFB, "R11 capture after enable");
        tach_to(1'b1);

        // R4 underflow
        ticks(1);
        ticks_back_to_back(65535);
        idle(2);
        check("R4 count at zero", count, 16'h0000);
        expect_evt(K_UNF, 16'hFFFB, "R4 underflow");
        ticks(1);
        idle(3);
        check("R4 capture kept", capture, 16'hFFFB);

        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R12 missed events actual=%0d expected=0", expq.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule